// File: doc/BRIEF.md
# Radio Frame Buffer

This block is the single-frame store that sits between a processor and a packet radio's transmit and receive datapath. It holds 128 bytes, which is enough for one frame of maximum length, either a frame that has arrived or one that is queued to go out. The processor reaches it through a byte-wide port decoded from a fixed window of its I/O address map. The radio datapath reaches it through a second, independent byte-wide port that is addressed by a byte index and carries start-of-frame and end-of-frame markers.

Processor access depends on the radio's power and sleep state. While the radio is power-reduced or asleep, processor reads return zero and processor writes are lost. The block keeps a frame-valid flag. The flag rises at end-of-frame. It falls when a new frame starts, when the radio sleeps or is powered down, and at reset. The first byte the radio writes in a frame is captured as the frame length.

By default nothing stops an incoming frame from overwriting one that the processor is still reading. Two aids are provided for this. A protect input lets the radio controller shut out radio-side writes. An overwrite-warning flag reports that a frame the processor has not yet acknowledged was hit.

Top module: `frame_store`

## Requirements
- R1: The store holds 128 bytes. A processor write at an address from 0x180 to 0x1FF stores its byte at index address[6:0]. A processor read in the same window returns that byte on cpuRdata in the cycle after the read strobe.
- R2: A processor access whose address is outside 0x180..0x1FF changes no stored byte, and a read at such an address returns 0x00 in the next cycle.
- R3: The radio port writes and reads by byte index, and its read data appears on rfRdata one cycle after rfRe. Both ports may operate in the same cycle on different bytes, and each completes as if it were alone.
- R4: If both ports write the same byte in the same cycle, the radio-port value is stored. A read on one port in the same cycle as a write to that byte on the other port returns the old byte.
- R5: While radioPowerOff or radioSleep is high, a processor read returns 0x00 in the next cycle and a processor write is dropped.
- R6: Without rxProtect, a radio write overwrites a byte even while frameValid is high.
- R7: frameValid is 0 after reset. It is cleared the cycle after radioSleep or radioPowerOff is high, and the cycle after an accepted rfSof.
- R8: An accepted rfEof sets frameValid in the next cycle. It takes priority over an rfSof in the same cycle.
- R9: frameLen takes the data of the first accepted radio write in the cycle of rfSof or after it. Later writes in the same frame leave frameLen unchanged. frameLen is 0 after reset, sleep or power reduction.
- R10: While rxProtect is high, radio writes, rfSof and rfEof are ignored. Stored bytes, frameValid and frameLen keep their values.
- R11: overwriteWarn is set after an accepted radio write or rfSof that arrives while frameValid is high and the frame has not been acknowledged. A pulse on cpuAck acknowledges the frame and clears the warning. An accepted rfEof withdraws the acknowledgement. Sleep, power reduction and reset clear both the warning and the acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Processor I/O address |
| cpuWe | input | 1 | Processor write strobe |
| cpuRe | input | 1 | Processor read strobe |
| cpuWdata | input | 8 | Processor write data |
| cpuRdata | output | 8 | Processor read data, registered |
| cpuAck | input | 1 | Processor acknowledges the held frame |
| radioPowerOff | input | 1 | Radio power reduction active |
| radioSleep | input | 1 | Radio in sleep state |
| rxProtect | input | 1 | Block radio-side writes and frame markers |
| rfWe | input | 1 | Radio-side write strobe |
| rfRe | input | 1 | Radio-side read strobe |
| rfIdx | input | 7 | Radio-side byte index |
| rfWdata | input | 8 | Radio-side write data |
| rfRdata | output | 8 | Radio-side read data, registered |
| rfSof | input | 1 | Start-of-frame marker |
| rfEof | input | 1 | End-of-frame marker |
| frameValid | output | 1 | A complete frame is held |
| frameLen | output | 8 | Captured frame length byte |
| overwriteWarn | output | 1 | An unacknowledged frame was overwritten |

## Verification
The hardest case to reach from the ports is a write collision: both ports must hit the same byte in one clock edge, or one port must read a byte while the other writes it. The bench drives both ports inside a single negedge-to-negedge window. It then reads the byte back in a later cycle to see which value was kept, and which value the concurrent read returned. A second hard case is the warning's acknowledge cycle. The bench builds a complete frame, overwrites it, acknowledges it, and then closes a new frame. This shows that an accepted end-of-frame re-arms the warning.

// File: rtl/frame_store_pkg.sv
package frame_store_pkg;
  // Strobes the control issues to the datapath each cycle
  typedef struct packed {
    logic cpuWr;   // processor write accepted
    logic cpuRd;   // processor read accepted
    logic rfWr;    // radio write accepted
    logic rfRd;    // radio read
    logic lenCap;  // capture frame length from radio write data
    logic lenClr;  // clear frame length
  } fbStrobe_t;
endpackage

// File: rtl/frame_store_ctrl.sv
module frame_store_ctrl
  import frame_store_pkg::*;
#(
  parameter int BUS_AW = 16,
  parameter int IDX_W = 7,
  parameter logic [BUS_AW-1:0] WIN_BASE = 16'h0180
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [BUS_AW-1:IDX_W]   cpuAddrHi,
  input  logic                    cpuWe,
  input  logic                    cpuRe,
  input  logic                    cpuAck,
  input  logic                    radioPowerOff,
  input  logic                    radioSleep,
  input  logic                    rxProtect,
  input  logic                    rfWe,
  input  logic                    rfRe,
  input  logic                    rfSof,
  input  logic                    rfEof,
  output fbStrobe_t               strb,
  output logic                    frameValid,
  output logic                    overwriteWarn
);
  logic inWin, gateOff, rfWrOk, sofOk, eofOk;
  logic lenPending, acked;

  assign inWin   = (cpuAddrHi == WIN_BASE[BUS_AW-1:IDX_W]);
  assign gateOff = radioPowerOff | radioSleep;
  assign rfWrOk  = rfWe & ~rxProtect;
  assign sofOk   = rfSof & ~rxProtect;
  assign eofOk   = rfEof & ~rxProtect;

  always_comb begin
    strb        = '0;
    strb.cpuWr  = cpuWe & inWin & ~gateOff;
    strb.cpuRd  = cpuRe & inWin & ~gateOff;
    strb.rfWr   = rfWrOk;
    strb.rfRd   = rfRe;
    strb.lenClr = gateOff;
    strb.lenCap = rfWrOk & (lenPending | sofOk) & ~gateOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenPending    <= 1'b0;
      frameValid    <= 1'b0;
      acked         <= 1'b0;
      overwriteWarn <= 1'b0;
    end else if (gateOff) begin
      lenPending    <= 1'b0;
      frameValid    <= 1'b0;
      acked         <= 1'b0;
      overwriteWarn <= 1'b0;
    end else begin
      if (strb.lenCap)  lenPending <= 1'b0;
      else if (sofOk)   lenPending <= 1'b1;

      if (eofOk)        frameValid <= 1'b1;
      else if (sofOk)   frameValid <= 1'b0;

      if (eofOk)        acked <= 1'b0;
      else if (cpuAck)  acked <= 1'b1;

      if (cpuAck)       overwriteWarn <= 1'b0;
      else if ((rfWrOk | sofOk) & frameValid & ~acked) overwriteWarn <= 1'b1;
    end
  end

  assert_invalid_on_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    (radioSleep || radioPowerOff) |=> !frameValid);

  assert_valid_on_eof_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rfEof && !rxProtect && !radioSleep && !radioPowerOff) |=> frameValid);

  assert_warn_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (overwriteWarn && !cpuAck && !radioSleep && !radioPowerOff) |=> overwriteWarn);

  assert_warn_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overwriteWarn) |-> $past(frameValid));
endmodule

// File: rtl/frame_store_dp.sv
module frame_store_dp
  import frame_store_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbStrobe_t         strb,
  input  logic [IDX_W-1:0]  cpuIdx,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [IDX_W-1:0]  rfIdx,
  input  logic [DATA_W-1:0] rfWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [DATA_W-1:0] rfRdata,
  output logic [DATA_W-1:0] frameLen
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Radio write comes second so it wins a same-byte collision
  always_ff @(posedge clk) begin
    if (strb.cpuWr) mem[cpuIdx] <= cpuWdata;
    if (strb.rfWr)  mem[rfIdx]  <= rfWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdata <= '0;
      rfRdata  <= '0;
      frameLen <= '0;
    end else begin
      cpuRdata <= strb.cpuRd ? mem[cpuIdx] : '0;
      rfRdata  <= strb.rfRd  ? mem[rfIdx]  : '0;
      if (strb.lenClr)      frameLen <= '0;
      else if (strb.lenCap) frameLen <= rfWdata;
    end
  end

  assert_len_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lenCap && !strb.lenClr) |=> (frameLen == $past(rfWdata)));

  assert_idle_read_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cpuRd |=> (cpuRdata == '0));
endmodule

// File: rtl/frame_store.sv
module frame_store
  import frame_store_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DATA_W = 8,
  parameter int BUS_AW = 16,
  parameter logic [BUS_AW-1:0] WIN_BASE = 16'h0180,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic              cpuRe,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              cpuAck,
  input  logic              radioPowerOff,
  input  logic              radioSleep,
  input  logic              rxProtect,
  input  logic              rfWe,
  input  logic              rfRe,
  input  logic [IDX_W-1:0]  rfIdx,
  input  logic [DATA_W-1:0] rfWdata,
  output logic [DATA_W-1:0] rfRdata,
  input  logic              rfSof,
  input  logic              rfEof,
  output logic              frameValid,
  output logic [DATA_W-1:0] frameLen,
  output logic              overwriteWarn
);
  fbStrobe_t strb;

  frame_store_ctrl #(.BUS_AW(BUS_AW), .IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .cpuAddrHi(cpuAddr[BUS_AW-1:IDX_W]),
    .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuAck(cpuAck),
    .radioPowerOff(radioPowerOff), .radioSleep(radioSleep), .rxProtect(rxProtect),
    .rfWe(rfWe), .rfRe(rfRe), .rfSof(rfSof), .rfEof(rfEof),
    .strb(strb), .frameValid(frameValid), .overwriteWarn(overwriteWarn)
  );

  frame_store_dp #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuIdx(cpuAddr[IDX_W-1:0]), .cpuWdata(cpuWdata),
    .rfIdx(rfIdx), .rfWdata(rfWdata),
    .cpuRdata(cpuRdata), .rfRdata(rfRdata), .frameLen(frameLen)
  );

  assert_gated_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRe && (radioPowerOff || radioSleep)) |=> (cpuRdata == '0));

  assert_outside_read_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRe && (cpuAddr[BUS_AW-1:IDX_W] != WIN_BASE[BUS_AW-1:IDX_W])) |=> (cpuRdata == '0));

  assert_protect_holds_len_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxProtect && !radioSleep && !radioPowerOff) |=> $stable(frameLen));

  assert_protect_holds_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxProtect && !radioSleep && !radioPowerOff && !cpuAck) |=> $stable(frameValid));
endmodule

// File: tb/sim_frame_store.sv
module sim_frame_store;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuWe = 0, cpuRe = 0, cpuAck = 0;
  logic [7:0] cpuWdata = '0, cpuRdata;
  logic radioPowerOff = 0, radioSleep = 0, rxProtect = 0;
  logic rfWe = 0, rfRe = 0, rfSof = 0, rfEof = 0;
  logic [6:0] rfIdx = '0;
  logic [7:0] rfWdata = '0, rfRdata, frameLen;
  logic frameValid, overwriteWarn;

  int errors = 0, checks = 0;
  logic [7:0] model [128];
  logic [7:0] rd;

  always #2 clk = ~clk;

  frame_store u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuRe(cpuRe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuAck(cpuAck),
    .radioPowerOff(radioPowerOff), .radioSleep(radioSleep), .rxProtect(rxProtect),
    .rfWe(rfWe), .rfRe(rfRe), .rfIdx(rfIdx), .rfWdata(rfWdata), .rfRdata(rfRdata),
    .rfSof(rfSof), .rfEof(rfEof), .frameValid(frameValid), .frameLen(frameLen),
    .overwriteWarn(overwriteWarn)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpuWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpuAddr = a; cpuWdata = d; cpuWe = 1;
    @(negedge clk); cpuWe = 0;
  endtask

  task automatic cpuRd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); cpuAddr = a; cpuRe = 1;
    @(negedge clk); cpuRe = 0; d = cpuRdata;
  endtask

  task automatic rfWr(input int i, input logic [7:0] d, input logic s, input logic e);
    @(negedge clk); rfIdx = 7'(i); rfWdata = d; rfWe = 1; rfSof = s; rfEof = e;
    @(negedge clk); rfWe = 0; rfSof = 0; rfEof = 0;
  endtask

  task automatic rfRd(input int i, output logic [7:0] d);
    @(negedge clk); rfIdx = 7'(i); rfRe = 1;
    @(negedge clk); rfRe = 0; d = rfRdata;
  endtask

  task automatic pulseAck();
    @(negedge clk); cpuAck = 1;
    @(negedge clk); cpuAck = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset valid", 16'(frameValid), 0);
    chk("R9 reset len", 16'(frameLen), 0);
    chk("R11 reset warn", 16'(overwriteWarn), 0);
    chk("R1 reset rdata", 16'(cpuRdata), 0);
    rstN = 1;

    // R1: full processor sweep
    for (int i = 0; i < 128; i++) begin
      model[i] = 8'((i * 37 + 11) & 255);
      cpuWr(16'h0180 + 16'(i), model[i]);
    end
    for (int i = 0; i < 128; i++) begin
      cpuRd(16'h0180 + 16'(i), rd);
      chk("R1 cpu readback", 16'(rd), 16'(model[i]));
    end
    // R3: radio reads, then radio writes seen by processor
    for (int i = 0; i < 128; i++) begin
      rfRd(i, rd);
      chk("R3 rf read", 16'(rd), 16'(model[i]));
    end
    for (int i = 0; i < 128; i++) begin
      model[i] = 8'(((i ^ 8'h5A) + 3 * i) & 255);
      rfWr(i, model[i], 0, 0);
    end
    for (int i = 0; i < 128; i++) begin
      cpuRd(16'h0180 + 16'(i), rd);
      chk("R3 rf write seen", 16'(rd), 16'(model[i]));
    end
    // R3: both ports same cycle, different bytes
    @(negedge clk);
    cpuAddr = 16'h0185; cpuWdata = 8'hC3; cpuWe = 1;
    rfIdx = 7'd9; rfRe = 1;
    @(negedge clk); cpuWe = 0; rfRe = 0;
    chk("R3 parallel rf read", 16'(rfRdata), 16'(model[9]));
    model[5] = 8'hC3;
    cpuRd(16'h0185, rd);
    chk("R3 parallel cpu write", 16'(rd), 16'hC3);

    // R2: outside the window
    cpuWr(16'h017F, 8'hEE);
    cpuWr(16'h0200, 8'hEE);
    cpuWr(16'h0080, 8'hEE);
    cpuRd(16'h017F, rd);  chk("R2 read below", 16'(rd), 0);
    cpuRd(16'h0200, rd);  chk("R2 read above", 16'(rd), 0);
    cpuRd(16'h01FF, rd);  chk("R2 idx127 kept", 16'(rd), 16'(model[127]));
    cpuRd(16'h0180, rd);  chk("R2 idx0 kept", 16'(rd), 16'(model[0]));

    // R5: gating
    radioPowerOff = 1;
    cpuWr(16'h0186, 8'h33);
    cpuRd(16'h0186, rd);  chk("R5 poweroff read", 16'(rd), 0);
    radioPowerOff = 0; radioSleep = 1;
    cpuWr(16'h0187, 8'h34);
    cpuRd(16'h0187, rd);  chk("R5 sleep read", 16'(rd), 0);
    radioSleep = 0;
    cpuRd(16'h0186, rd);  chk("R5 write dropped a", 16'(rd), 16'(model[6]));
    cpuRd(16'h0187, rd);  chk("R5 write dropped b", 16'(rd), 16'(model[7]));

    // R4: collisions
    @(negedge clk);
    cpuAddr = 16'h0190; cpuWdata = 8'h11; cpuWe = 1;
    rfIdx = 7'h10; rfWdata = 8'h22; rfWe = 1;
    @(negedge clk); cpuWe = 0; rfWe = 0;
    model[16] = 8'h22;
    cpuRd(16'h0190, rd);  chk("R4 rf wins", 16'(rd), 16'h22);
    @(negedge clk);
    cpuAddr = 16'h01A0; cpuRe = 1;
    rfIdx = 7'h20; rfWdata = 8'h9D; rfWe = 1;
    @(negedge clk); cpuRe = 0; rfWe = 0;
    chk("R4 cpu read old", 16'(cpuRdata), 16'(model[32]));
    model[32] = 8'h9D;
    cpuRd(16'h01A0, rd);  chk("R4 new stored", 16'(rd), 16'h9D);
    @(negedge clk);
    cpuAddr = 16'h01A1; cpuWdata = 8'h6E; cpuWe = 1;
    rfIdx = 7'h21; rfRe = 1;
    @(negedge clk); cpuWe = 0; rfRe = 0;
    chk("R4 rf read old", 16'(rfRdata), 16'(model[33]));
    model[33] = 8'h6E;

    // R9 / R8: frame build
    rfWr(0, 8'd20, 1, 0);
    model[0] = 8'd20;
    chk("R9 len captured", 16'(frameLen), 20);
    chk("R7 sof clears", 16'(frameValid), 0);
    rfWr(1, 8'd99, 0, 0);  model[1] = 8'd99;
    chk("R9 len held", 16'(frameLen), 20);
    rfWr(2, 8'd7, 0, 1);   model[2] = 8'd7;
    chk("R8 eof sets", 16'(frameValid), 1);
    chk("R11 no warn", 16'(overwriteWarn), 0);

    // R6 / R11: overwrite while valid
    rfWr(1, 8'h44, 0, 0);  model[1] = 8'h44;
    chk("R11 warn set", 16'(overwriteWarn), 1);
    cpuRd(16'h0181, rd);   chk("R6 overwritten", 16'(rd), 16'h44);
    pulseAck();
    chk("R11 ack clears", 16'(overwriteWarn), 0);
    rfWr(3, 8'h01, 0, 0);  model[3] = 8'h01;
    chk("R11 acked no warn", 16'(overwriteWarn), 0);

    // R10: protect
    rxProtect = 1;
    rfWr(4, 8'h77, 1, 0);
    chk("R10 valid kept", 16'(frameValid), 1);
    chk("R10 len kept", 16'(frameLen), 20);
    rxProtect = 0;
    cpuRd(16'h0184, rd);   chk("R10 byte kept", 16'(rd), 16'(model[4]));
    rfWr(5, 8'd3, 1, 0);   model[5] = 8'd3;
    chk("R7 sof clears valid", 16'(frameValid), 0);
    chk("R11 acked sof no warn", 16'(overwriteWarn), 0);
    rxProtect = 1;
    rfWr(6, 8'h55, 0, 1);
    chk("R10 eof ignored", 16'(frameValid), 0);
    rxProtect = 0;

    // R8: sof and eof together
    rfWr(7, 8'd42, 1, 1);  model[7] = 8'd42;
    chk("R8 eof over sof", 16'(frameValid), 1);
    chk("R9 len same cycle", 16'(frameLen), 42);
    rfWr(8, 8'd5, 1, 0);   model[8] = 8'd5;
    chk("R11 warn on sof", 16'(overwriteWarn), 1);
    chk("R7 sof clears again", 16'(frameValid), 0);
    chk("R9 new len", 16'(frameLen), 5);

    // R7 / R11 / R9: sleep, power, reset
    rfWr(9, 8'd1, 0, 1);   model[9] = 8'd1;
    @(negedge clk); radioSleep = 1;
    @(negedge clk); radioSleep = 0;
    chk("R7 sleep valid", 16'(frameValid), 0);
    chk("R11 sleep warn", 16'(overwriteWarn), 0);
    chk("R9 sleep len", 16'(frameLen), 0);
    rfWr(10, 8'd9, 1, 1);  model[10] = 8'd9;
    @(negedge clk); radioPowerOff = 1;
    @(negedge clk); radioPowerOff = 0;
    chk("R7 poweroff valid", 16'(frameValid), 0);
    rfWr(11, 8'd8, 1, 1);  model[11] = 8'd8;
    chk("R8 valid again", 16'(frameValid), 1);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    chk("R7 reset valid", 16'(frameValid), 0);
    chk("R9 reset len", 16'(frameLen), 0);

    // R1: final sweep against the model
    for (int i = 0; i < 128; i++) begin
      cpuRd(16'h0180 + 16'(i), rd);
      chk("R1 final sweep", 16'(rd), 16'(model[i]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule